// File: doc/BRIEF.md
# Synchronous Serial Transceiver (SPI-style, master or slave)

This block is a full-duplex byte-wide synchronous shift unit. It can act as clock master, where it drives the serial clock from an internal reload divider. It can also act as clock slave, where it follows an external clock that it first synchronises to the system clock. The host writes a byte into an 8-bit transmit holding register and reads received bytes from an 8-bit receive register. A transmit-empty flag and a receive-full flag pace the transfers. Every byte shifted out shifts one byte in at the same time.

Configuration inputs choose several options:
- the idle level of the clock and whether data leads the first clock edge by half a bit;
- the bit order, and inversion of both data lines;
- an optional start bit and stop bit around each byte;
- a free-running master clock.

The host sets these while the unit is idle. A transmit-idle status tells the host when the line has gone quiet, for example before it drops an external chip select.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, tx_empty_o=1, rx_full_o=0, tx_idle_o=1, sdo_o=1 (with inversion off), and a master drives sck_o at the idle level given by cpol_i.
- R2: In master mode without framing, each accepted byte produces exactly 8 clock pulses. The data bits appear on sdo_o one per pulse, in the selected order.
- R3: At the end of each byte, the bits sampled from sdi_i are stored in rx_data_o and rx_full_o is set. With sdo_o looped back to sdi_i, rx_data_o equals the byte written.
- R4: A write to an empty transmit register clears tx_empty_o. tx_empty_o rises again once the first bit of that byte has been fully sent, while tx_idle_o stays 0 until the byte ends.
- R5: A write while tx_empty_o=0 is ignored: the held byte is neither replaced nor sent twice.
- R6: With no transfer and no free-running clock, sck_o sits at the idle level: 0 when cpol_i=0, 1 when cpol_i=1.
- R7: With cpha_i=0, each data bit is on sdo_o half a bit before the clock leaves its idle level. With cpha_i=1, the bit changes at the same edge where the clock leaves idle. Input is sampled in mid-bit in both cases.
- R8: With framing on, each byte is sent as a 0 start bit, 8 data bits and a 1 stop bit, over 10 clock pulses. Only the 8 data bits reach rx_data_o.
- R9: With cont_clk_i=1, a master keeps one clock pulse per bit period going while idle. With cont_clk_i=0, it gives no pulses while idle.
- R10: The master bit period is div_i system cycles, clamped to the range 5..32768, so div_i=2 gives 5 cycles.
- R11: In slave mode, sck_oe_o=0 and bits move on edges of sck_i. If nothing was written, the slave sends all ones (before inversion) and still receives a full byte.
- R12: With inv_i=1, sdo_o and sdi_i are both inverted. An idle or unwritten slave therefore drives sdo_o=0.
- R13: With msb_first_i=1, bit 7 is the first data bit on the line and the first data bit received. With msb_first_i=0, bit 0 is first.
- R14: A pulse on rx_rd_i clears rx_full_o, unless a new byte completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: drive the clock from the divider; 0: follow sck_i |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase: 1 puts the data change on the first clock edge |
| frame_en_i | input | 1 | Adds a start bit and a stop bit around each byte |
| cont_clk_i | input | 1 | Free-running master clock |
| msb_first_i | input | 1 | Bit order |
| inv_i | input | 1 | Inverts both data lines |
| div_i | input | 16 | Master bit period in system cycles |
| tx_wr_i | input | 1 | Write strobe for the transmit register |
| tx_data_i | input | 8 | Byte to send |
| rx_rd_i | input | 1 | Read strobe for the receive register |
| tx_empty_o | output | 1 | Transmit register can take a byte |
| tx_idle_o | output | 1 | No byte pending or in flight |
| rx_data_o | output | 8 | Last received byte |
| rx_full_o | output | 1 | Unread received byte |
| sck_i | input | 1 | External serial clock (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe_o | output | 1 | Clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
The bench sweeps every combination of polarity, phase, bit order and framing in master loopback. It counts pulses per byte, so a design that stops one bit early or adds a pulse at the byte boundary fails the 8 and 10 pulse checks. It watches the exact edge at which bit 0 first appears and the moment the empty flag rises. A design that releases the holding register only at the end of the byte, or that launches data on the wrong edge for the chosen phase, shows up there. The slave runs include transfers with no byte written and with inversion on, which expose a slave that stays silent or drives the wrong idle level. A write into a full register must not cause a second byte to be sent.

// File: rtl/spi_xcvr_pkg.sv
`timescale 1ns/1ps
package spi_xcvr_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FRAME_W = BYTE_W + 2;

  function automatic logic [BYTE_W-1:0] flip_bits(input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
    return r;
  endfunction

  // bit 0 of the result goes out first; unframed bytes are padded with idle ones
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [BYTE_W-1:0] d,
                                                     input logic msb, input logic framed);
    logic [BYTE_W-1:0] ord;
    ord = msb ? flip_bits(d) : d;
    return framed ? {1'b1, ord, 1'b0} : {2'b11, ord};
  endfunction

  // samples enter at the top; the first sample ends at bit FRAME_W-n
  function automatic logic [BYTE_W-1:0] unpack_rx(input logic [FRAME_W-1:0] s,
                                                   input logic msb, input logic framed);
    logic [BYTE_W-1:0] ord;
    ord = framed ? s[FRAME_W-2:1] : s[FRAME_W-1:2];
    return msb ? flip_bits(ord) : ord;
  endfunction
endpackage

// File: rtl/spi_xcvr_baud.sv
`timescale 1ns/1ps
module spi_xcvr_baud #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_MIN = 5,
  parameter int unsigned DIV_MAX = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lead_o,
  output logic             mid_o,
  output logic             second_o
);
  logic [DIV_W-1:0] div_eff, half, cnt_q;
  logic             wrap;

  always_comb begin
    if (div_i < DIV_W'(DIV_MIN))      div_eff = DIV_W'(DIV_MIN);
    else if (div_i > DIV_W'(DIV_MAX)) div_eff = DIV_W'(DIV_MAX);
    else                              div_eff = div_i;
  end

  assign half = div_eff >> 1;
  assign wrap = cnt_q >= (div_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end

  assign lead_o   = run_i & wrap;
  assign mid_o    = run_i & (cnt_q == (half - DIV_W'(1)));
  assign second_o = cnt_q >= half;
endmodule

// File: rtl/spi_xcvr_edge.sv
`timescale 1ns/1ps
module spi_xcvr_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,    // clock already folded to active-high
  output logic lead_o,
  output logic trail_o
);
  logic [SYNC_N:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[SYNC_N-1:0], lvl_i};
  end

  assign lead_o  =  st_q[SYNC_N-1] & ~st_q[SYNC_N];
  assign trail_o = ~st_q[SYNC_N-1] &  st_q[SYNC_N];
endmodule

// File: rtl/spi_xcvr_core.sv
`timescale 1ns/1ps
module spi_xcvr_core
  import spi_xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              framed_i,
  input  logic              msb_first_i,
  input  logic              inv_i,
  input  logic              chain_i,
  input  logic              ev_start_i,
  input  logic              ev_launch_i,
  input  logic              ev_fin_i,
  input  logic              ev_sample_i,
  input  logic              ev_preload_i,
  input  logic              sdi_i,
  input  logic              tx_wr_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic              tx_empty_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sdo_bit_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_full_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);

  logic [BYTE_W-1:0]  hold_q, rx_q;
  logic [FRAME_W-1:0] sr_q, rsr_q, rsr_nxt;
  logic [CNT_W-1:0]   bcnt_q;
  logic               empty_q, busy_q, own_q, rxf_q;
  logic               last, done, advance, take_hold, start_dummy, sample;

  assign last        = bcnt_q == (framed_i ? CNT_W'(FRAME_W-1) : CNT_W'(BYTE_W-1));
  assign done        = busy_q & ev_fin_i & last;
  assign advance     = busy_q & ev_launch_i & ~done;
  assign take_hold   = ~empty_q & ((chain_i & ev_launch_i & (~busy_q | done))
                                   | (ev_preload_i & ~busy_q) | ev_start_i);
  assign start_dummy = ev_start_i & empty_q;
  assign sample      = ev_sample_i & (busy_q | ev_start_i);
  assign rsr_nxt     = sample ? {sdi_i ^ inv_i, rsr_q[FRAME_W-1:1]} : rsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      busy_q  <= 1'b0;
      own_q   <= 1'b0;
      bcnt_q  <= '0;
      sr_q    <= '1;
      rsr_q   <= '0;
      rx_q    <= '0;
      rxf_q   <= 1'b0;
    end else begin
      if (tx_wr_i && empty_q) begin
        hold_q  <= tx_data_i;
        empty_q <= 1'b0;
      end
      if (take_hold) begin
        sr_q   <= pack_frame(hold_q, msb_first_i, framed_i);
        busy_q <= 1'b1;
        bcnt_q <= '0;
        own_q  <= 1'b1;
      end else if (start_dummy) begin
        sr_q   <= '1;
        busy_q <= 1'b1;
        bcnt_q <= '0;
        own_q  <= 1'b0;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (advance) begin
        sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
        bcnt_q <= bcnt_q + CNT_W'(1);
        // holding register frees once the first bit has left
        if (bcnt_q == '0 && own_q) begin
          empty_q <= 1'b1;
          own_q   <= 1'b0;
        end
      end
      rsr_q <= rsr_nxt;
      if (done) begin
        rx_q  <= unpack_rx(rsr_nxt, msb_first_i, framed_i);
        rxf_q <= 1'b1;
      end else if (rx_rd_i) begin
        rxf_q <= 1'b0;
      end
    end
  end

  assign tx_empty_o = empty_q;
  assign busy_o     = busy_q;
  assign done_o     = done;
  assign sdo_bit_o  = busy_q ? sr_q[0] : 1'b1;
  assign rx_data_o  = rx_q;
  assign rx_full_o  = rxf_q;
endmodule

// File: rtl/spi_xcvr.sv
`timescale 1ns/1ps
module spi_xcvr #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_MIN = 5,
  parameter int unsigned DIV_MAX = 32768,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             frame_en_i,
  input  logic             cont_clk_i,
  input  logic             msb_first_i,
  input  logic             inv_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_wr_i,
  input  logic [7:0]       tx_data_i,
  input  logic             rx_rd_i,
  output logic             tx_empty_o,
  output logic             tx_idle_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_full_o,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe_o,
  input  logic             sdi_i,
  output logic             sdo_o
);
  logic lead_t, mid_t, second_h;
  logic lead_e, trail_e;
  logic busy, done, sdo_bit, tx_empty;
  logic ev_start, ev_launch, ev_fin, ev_sample, ev_preload;
  logic m_act;

  spi_xcvr_baud #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_baud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (master_i),
    .div_i   (div_i),
    .lead_o  (lead_t),
    .mid_o   (mid_t),
    .second_o(second_h)
  );

  spi_xcvr_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sck_i ^ cpol_i),
    .lead_o (lead_e),
    .trail_o(trail_e)
  );

  // event map: master runs on divider ticks, slave on synchronised clock edges
  always_comb begin
    if (master_i) begin
      ev_start   = 1'b0;
      ev_launch  = lead_t;
      ev_fin     = lead_t;
      ev_sample  = mid_t;
      ev_preload = 1'b0;
    end else begin
      ev_start   = lead_e & ~busy;
      ev_launch  = cpha_i ? (lead_e & busy) : trail_e;
      ev_fin     = trail_e;
      ev_sample  = cpha_i ? trail_e : lead_e;
      ev_preload = ~cpha_i;
    end
  end

  spi_xcvr_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .framed_i    (frame_en_i),
    .msb_first_i (msb_first_i),
    .inv_i       (inv_i),
    .chain_i     (master_i),
    .ev_start_i  (ev_start),
    .ev_launch_i (ev_launch),
    .ev_fin_i    (ev_fin),
    .ev_sample_i (ev_sample),
    .ev_preload_i(ev_preload),
    .sdi_i       (sdi_i),
    .tx_wr_i     (tx_wr_i),
    .tx_data_i   (tx_data_i),
    .rx_rd_i     (rx_rd_i),
    .tx_empty_o  (tx_empty),
    .busy_o      (busy),
    .done_o      (done),
    .sdo_bit_o   (sdo_bit),
    .rx_data_o   (rx_data_o),
    .rx_full_o   (rx_full_o)
  );

  assign m_act      = (busy | cont_clk_i) & (cpha_i ? ~second_h : second_h);
  assign sck_o      = master_i ? (m_act ^ cpol_i) : cpol_i;
  assign sck_oe_o   = master_i;
  assign sdo_o      = sdo_bit ^ inv_i;
  assign tx_empty_o = tx_empty;
  assign tx_idle_o  = ~busy & tx_empty;
endmodule

// File: rtl/spi_xcvr_chk.sv
`timescale 1ns/1ps
module spi_xcvr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic cpol_i,
  input logic cont_clk_i,
  input logic inv_i,
  input logic frame_en_i,
  input logic tx_wr_i,
  input logic rx_rd_i,
  input logic tx_empty_o,
  input logic tx_idle_o,
  input logic rx_full_o,
  input logic sck_o,
  input logic sdo_o,
  input logic busy_i,
  input logic done_i
);
  logic       act, act_q, busy_q, rise;
  logic [3:0] pcnt_q;

  assign act  = sck_o ^ cpol_i;
  assign rise = act & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      busy_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      act_q  <= act;
      busy_q <= busy_i;
      if (busy_i && !busy_q)   pcnt_q <= rise ? 4'd1 : 4'd0;
      else if (busy_i && rise) pcnt_q <= pcnt_q + 4'd1;
    end
  end

  a_r2_pulse_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && done_i |-> pcnt_q == (frame_en_i ? 4'd10 : 4'd8));
  a_r3_full_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(done_i));
  a_r4_empty_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && tx_empty_o |=> !tx_empty_o);
  a_r6_idle_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && !cont_clk_i && tx_idle_o |-> sck_o == cpol_i);
  a_r12_idle_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> sdo_o == ~inv_i);
  a_r14_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i && !done_i |=> !rx_full_o);
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .cpol_i    (cpol_i),
  .cont_clk_i(cont_clk_i),
  .inv_i     (inv_i),
  .frame_en_i(frame_en_i),
  .tx_wr_i   (tx_wr_i),
  .rx_rd_i   (rx_rd_i),
  .tx_empty_o(tx_empty_o),
  .tx_idle_o (tx_idle_o),
  .rx_full_o (rx_full_o),
  .sck_o     (sck_o),
  .sdo_o     (sdo_o),
  .busy_i    (busy),
  .done_i    (done)
);

// File: tb/spi_xcvr_test.sv
`timescale 1ns/1ps
module spi_xcvr_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic master = 1'b1, cpol = 1'b0, cpha = 1'b0, frm = 1'b0, cont = 1'b0;
  logic msb = 1'b0, inv = 1'b0, lb = 1'b1;
  logic [15:0] div = 16'd5;
  logic tx_wr = 1'b0, rx_rd = 1'b0, sck_in = 1'b0, sdi_drv = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_empty, tx_idle, rx_full, sck_out, sck_oe, sdo, sdi;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign sdi = lb ? sdo : sdi_drv;

  spi_xcvr uut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master), .cpol_i(cpol), .cpha_i(cpha),
    .frame_en_i(frm), .cont_clk_i(cont), .msb_first_i(msb), .inv_i(inv), .div_i(div),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .tx_empty_o(tx_empty),
    .tx_idle_o(tx_idle), .rx_data_o(rx_data), .rx_full_o(rx_full), .sck_i(sck_in),
    .sck_o(sck_out), .sck_oe_o(sck_oe), .sdi_i(sdi), .sdo_o(sdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  // master loopback transfer; decodes sdo at every clock leading edge
  task automatic m_xfer(input logic [7:0] d, input logic f, input logic m, input logic p,
                        input logic h, input logic iv, input int dexp, input logic [15:0] dv);
    int ncyc = 0, np = 0, e0 = 0, e1 = 0, nb;
    logic [9:0] got = '0, expv;
    logic [7:0] ord;
    logic act, pact, psdo, fprev = 1'b0, idle_lvl;
    @(negedge clk);
    master = 1'b1; lb = 1'b1; frm = f; msb = m; cpol = p; cpha = h; inv = iv; div = dv;
    cont = 1'b0;
    cyc(3);
    put(d);
    chk("R4 empty cleared by write", {31'd0, tx_empty}, 32'd0);
    pact = sck_out ^ p; psdo = sdo;
    while (ncyc < 3000) begin
      @(negedge clk); ncyc++;
      act = sck_out ^ p;
      if (act && !pact) begin
        if (np < 10) got[np] = sdo;
        if (np == 0) begin
          fprev = psdo; e0 = ncyc;
          chk("R4 empty low during first bit", {31'd0, tx_empty}, 32'd0);
        end
        if (np == 1) e1 = ncyc;
        if (np == 2) chk("R4 empty high after first bit, still busy",
                         {30'd0, tx_empty, tx_idle}, 32'd2);
        np++;
      end
      pact = act; psdo = sdo;
      if (tx_idle && np > 0) break;
    end
    nb = f ? 10 : 8;
    ord = m ? rev8(d) : d;
    expv = f ? ({1'b1, ord, 1'b0} ^ {10{iv}}) : {2'b00, ord ^ {8{iv}}};
    chk(f ? "R8 pulses per framed byte" : "R2 pulses per byte", np, nb);
    chk(m ? "R13 line bits msb first" : "R2 line bits lsb first", {22'd0, got}, {22'd0, expv});
    if (f) chk("R8 start and stop bit", {30'd0, got[9], got[0]}, {30'd0, ~iv, iv});
    if (iv) chk("R12 inverted line data", {24'd0, got[7:0]}, {24'd0, expv[7:0]});
    chk("R3 loopback byte", {23'd0, rx_full, rx_data}, {23'd1, d});
    chk("R10 bit period", e1 - e0, dexp);
    idle_lvl = ~iv;
    if (expv[0] != idle_lvl)
      chk("R7 level before first edge", {31'd0, fprev}, {31'd0, h ? idle_lvl : expv[0]});
    cyc(2);
    chk("R6 clock idle level", {31'd0, sck_out}, {31'd0, p});
    take();
    chk("R14 read clears full", {31'd0, rx_full}, 32'd0);
  endtask

  // slave transfer driven by bench clock; half period 8 cycles
  task automatic s_xfer(input logic [7:0] dtx, input logic [7:0] din, input logic wr,
                        input logic m, input logic p, input logic h, input logic iv);
    logic [7:0] ordi, ordo, got = '0, expo, expr;
    @(negedge clk);
    master = 1'b0; lb = 1'b0; frm = 1'b0; msb = m; cpol = p; cpha = h; inv = iv;
    sck_in = p;
    cyc(6);
    if (wr) put(dtx);
    cyc(8);
    chk("R11 clock output disabled", {31'd0, sck_oe}, 32'd0);
    ordi = m ? rev8(din) : din;
    ordo = m ? rev8(dtx) : dtx;
    if (!h) begin
      sdi_drv = ordi[0];
      cyc(8);
      for (int i = 0; i < 8; i++) begin
        got[i] = sdo;
        sck_in = ~p; cyc(8);
        sck_in = p; if (i < 7) sdi_drv = ordi[i+1];
        cyc(8);
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        sck_in = ~p; sdi_drv = ordi[i]; cyc(8);
        got[i] = sdo;
        sck_in = p; cyc(8);
      end
    end
    cyc(6);
    expo = (wr ? ordo : 8'hFF) ^ {8{iv}};
    expr = iv ? ~din : din;
    chk(wr ? "R11 slave line bits" : "R11 slave dummy ones", {24'd0, got}, {24'd0, expo});
    chk(m ? "R13 slave rx msb first" : "R11 slave rx byte", {23'd0, rx_full, rx_data},
        {23'd1, expr});
    chk("R4 slave empty after byte", {30'd0, tx_empty, tx_idle}, 32'd3);
    take();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k = 0;
    int ed;
    logic a, pa;
    cyc(3);
    chk("R1 reset flags", {28'd0, tx_empty, rx_full, tx_idle, sdo}, 32'b1011);
    chk("R1 reset clock", {30'd0, sck_out, sck_oe}, 32'b01);
    rst_ni = 1'b1;
    cyc(3);
    chk("R6 idle clock low", {31'd0, sck_out}, 32'd0);

    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int m = 0; m < 2; m++)
          for (int f = 0; f < 2; f++)
            for (int b = 0; b < 2; b++) begin
              m_xfer(8'h5A ^ 8'(k * 37), f[0], m[0], p[0], h[0], 1'b0, 5, 16'd5);
              k++;
            end

    m_xfer(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5, 16'd2);    // R10 clamp low
    m_xfer(8'h0F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12, 16'd12);  // R10 other period
    m_xfer(8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5, 16'd5);    // R12 master
    m_xfer(8'h81, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 7, 16'd7);

    // R5: second write while full is dropped
    @(negedge clk); frm = 1'b0; msb = 1'b0; cpol = 1'b0; cpha = 1'b0; inv = 1'b0; div = 16'd5;
    put(8'h3E);
    put(8'hE7);
    ed = 0;
    while (!tx_idle && ed < 500) begin cyc(1); ed++; end
    cyc(2);
    chk("R5 first byte kept", {24'd0, rx_data}, 32'h3E);
    take();
    cyc(80);
    chk("R5 no second byte", {30'd0, rx_full, tx_idle}, 32'd1);

    // R9: free-running clock while idle
    @(negedge clk); cont = 1'b1;
    cyc(7);
    ed = 0; pa = sck_out;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); a = sck_out;
      if (a && !pa) ed++;
      pa = a;
    end
    chk("R9 pulses while idle with free clock", ed, 10);
    chk("R9 still idle", {31'd0, tx_idle}, 32'd1);
    @(negedge clk); cont = 1'b0;
    cyc(7);
    ed = 0; pa = sck_out;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); a = sck_out;
      if (a && !pa) ed++;
      pa = a;
    end
    chk("R9 no pulses when off", ed, 0);

    // slave sweep
    k = 0;
    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int m = 0; m < 2; m++) begin
          s_xfer(8'hB4 ^ 8'(k * 29), 8'h6D ^ 8'(k * 53), 1'b1, m[0], p[0], h[0], 1'b0);
          k++;
        end
    s_xfer(8'h00, 8'h2C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);       // R11 dummy
    @(negedge clk); inv = 1'b1; master = 1'b0;
    cyc(2);
    chk("R12 slave idle output low", {31'd0, sdo}, 32'd0);
    s_xfer(8'h00, 8'h71, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);       // R12 dummy inverted
    s_xfer(8'hA9, 8'h18, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule